// File: doc/BRIEF.md
# Single-Sector Disk Read Sequencer

This block runs the host side of a one-sector read from a disk that uses the classic eight-port register file. A request carries a 28-bit logical block address. The sequencer first polls the status port until the drive is idle and ready. It then programs the register file in a fixed order and issues the read command. It polls status a second time and pulls the sector from the data port as a run of 32-bit words.

Each port access lasts exactly one clock cycle and is marked by a strobe. On a write, the byte to store is on `bus_wdata`. On a read, the drive puts its answer on `bus_rdata` during the strobe cycle, and the sequencer samples it at the clock edge that closes that cycle.

Each sector word is presented on a word output with a one-cycle valid. A one-cycle done pulse follows the last word. If the drive reports a fault after the command, a one-cycle error pulse is raised and the block goes back to idle without touching the data port.

Top module: `ata_sector_reader`

## Requirements
- R1: After accepting a request, the block reads the status port 0x1F7 once per cycle until a read returns bit 7 (busy) = 0 and bit 6 (ready) = 1. No register write happens before that read, and the first write comes in the cycle directly after it.
- R2: The first write stores the value 1 to the sector-count port 0x1F2.
- R3: The next three writes store address bits 7:0 to port 0x1F3, bits 15:8 to port 0x1F4 and bits 23:16 to port 0x1F5.
- R4: The fifth write stores 0xE0 OR address bits 27:24 to port 0x1F6. This selects block addressing on the master drive.
- R5: The sixth and last write stores command 0x20 to port 0x1F7. The six writes occupy six consecutive cycles, and exactly six writes are made per request.
- R6: After the command, status at 0x1F7 is read once per cycle while busy = 1, whatever the other bits hold. A read with busy = 0, ready = 1 and bit 0 (fault) = 0 starts the data phase in the next cycle. A read with busy = 0 and ready = 0 keeps polling.
- R7: The data phase reads port 0x1F0 128 times in consecutive cycles. Each word read is shown on `word_data` with `word_valid` high in the cycle after its read cycle, in read order.
- R8: `done` is high for exactly one cycle, in the cycle after the 128th `word_valid`. After that the block makes no further access until the next request.
- R9: If a post-command status read returns busy = 0 and fault = 1, `err` is high for one cycle in the following cycle. Fault takes priority over ready. The data port is never read and no word is output, and the block is idle and accepts the next request.
- R10: `req_valid` is ignored while a request is in progress. It neither restarts the write sequence nor changes the address that is written.
- R11: While reset is high and right after it, `bus_stb`, `word_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to read one sector, sampled only when idle |
| req_lba | input | 28 | Block address of the requested sector |
| bus_stb | output | 1 | Port access strobe, one cycle per access |
| bus_we | output | 1 | 1 for a port write, 0 for a port read |
| bus_addr | output | 10 | Port address |
| bus_wdata | output | 8 | Byte written to the port |
| bus_rdata | input | 32 | Drive answer for a read, valid during the strobe cycle |
| word_valid | output | 1 | Sector word valid |
| word_data | output | 32 | Sector word |
| done | output | 1 | One-cycle pulse after the last word |
| err | output | 1 | One-cycle pulse on a drive fault after the command |

## Verification
The bench's drive model sweeps the number of busy replies before the command and after it, and the number of idle-but-not-ready replies before the command. This separates a sequencer that checks both status bits from one that checks only busy, and it shows whether the first write and the first data read wait for the right status. While busy, post-command replies also carry the ready and fault bits, so acting on them too early is caught. Every sweep point runs once with a clean finish and once with a fault. This shows that a fault stops the transfer and that the block still takes a fresh request afterwards. Addresses with all-zero, all-one and mixed bytes check the byte split and the mode bits, and requests raised mid-transfer check that they are ignored.

// File: rtl/ata_rd_pkg.sv
package ata_rd_pkg;

  localparam int LBA_BITS = 28;
  localparam int OFS_W    = 3;

  // port offsets from the register-file base; the drive decodes these
  localparam logic [OFS_W-1:0] OFS_DATA    = 3'd0;
  localparam logic [OFS_W-1:0] OFS_SECCNT  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LBA_LO  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_LBA_MID = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LBA_HI  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_DEVSEL  = 3'd6;
  localparam logic [OFS_W-1:0] OFS_CMDSTAT = 3'd7;

  // status bit positions
  localparam int SB_BUSY  = 7;
  localparam int SB_READY = 6;
  localparam int SB_FAULT = 0;

  localparam logic [7:0] CMD_READ_ONE  = 8'h20;
  localparam logic [7:0] DEVSEL_BLK_M0 = 8'hE0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_PRE,
    ST_WR_CNT,
    ST_WR_LBA0,
    ST_WR_LBA1,
    ST_WR_LBA2,
    ST_WR_DEV,
    ST_WR_CMD,
    ST_POLL_POST,
    ST_XFER,
    ST_LAST
  } seq_state_t;

  typedef struct packed {
    logic             stb;
    logic             we;
    logic [OFS_W-1:0] ofs;
    logic [7:0]       wdata;
  } port_op_t;

endpackage

// File: rtl/ata_rd_wordcnt.sv
module ata_rd_wordcnt #(
  parameter int WORDS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ata_rd_opgen.sv
module ata_rd_opgen
  import ata_rd_pkg::*;
(
  input  seq_state_t          st,
  input  logic [LBA_BITS-1:0] lba,
  output port_op_t            op
);
  always_comb begin
    op = '0;
    case (st)
      ST_POLL_PRE, ST_POLL_POST: begin
        op.stb = 1'b1;
        op.ofs = OFS_CMDSTAT;
      end
      ST_WR_CNT: begin
        op.stb   = 1'b1;
        op.we    = 1'b1;
        op.ofs   = OFS_SECCNT;
        op.wdata = 8'd1;
      end
      ST_WR_LBA0: begin
        op.stb   = 1'b1;
        op.we    = 1'b1;
        op.ofs   = OFS_LBA_LO;
        op.wdata = lba[7:0];
      end
      ST_WR_LBA1: begin
        op.stb   = 1'b1;
        op.we    = 1'b1;
        op.ofs   = OFS_LBA_MID;
        op.wdata = lba[15:8];
      end
      ST_WR_LBA2: begin
        op.stb   = 1'b1;
        op.we    = 1'b1;
        op.ofs   = OFS_LBA_HI;
        op.wdata = lba[23:16];
      end
      ST_WR_DEV: begin
        op.stb   = 1'b1;
        op.we    = 1'b1;
        op.ofs   = OFS_DEVSEL;
        op.wdata = DEVSEL_BLK_M0 | {4'h0, lba[27:24]};
      end
      ST_WR_CMD: begin
        op.stb   = 1'b1;
        op.we    = 1'b1;
        op.ofs   = OFS_CMDSTAT;
        op.wdata = CMD_READ_ONE;
      end
      ST_XFER: begin
        op.stb = 1'b1;
        op.ofs = OFS_DATA;
      end
      default: op = '0;
    endcase
  end
endmodule

// File: rtl/ata_rd_fsm.sv
module ata_rd_fsm
  import ata_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [7:0] status,
  input  logic       last,
  output seq_state_t state,
  output seq_state_t nstate,
  output logic       take_req,
  output logic       word_cap,
  output logic       raise_err,
  output logic       raise_done
);
  logic idle_rdy;
  logic faulted;

  assign idle_rdy = !status[SB_BUSY] && status[SB_READY];
  assign faulted  = !status[SB_BUSY] && status[SB_FAULT];

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE:      if (req_valid) nstate = ST_POLL_PRE;
      ST_POLL_PRE:  if (idle_rdy) nstate = ST_WR_CNT;
      ST_WR_CNT:    nstate = ST_WR_LBA0;
      ST_WR_LBA0:   nstate = ST_WR_LBA1;
      ST_WR_LBA1:   nstate = ST_WR_LBA2;
      ST_WR_LBA2:   nstate = ST_WR_DEV;
      ST_WR_DEV:    nstate = ST_WR_CMD;
      ST_WR_CMD:    nstate = ST_POLL_POST;
      ST_POLL_POST: begin
        if (faulted)       nstate = ST_IDLE;
        else if (idle_rdy) nstate = ST_XFER;
      end
      ST_XFER:      if (last) nstate = ST_LAST;
      ST_LAST:      nstate = ST_IDLE;
      default:      nstate = ST_IDLE;
    endcase
  end

  assign take_req   = (state == ST_IDLE) && req_valid;
  assign word_cap   = (state == ST_XFER);
  assign raise_err  = (state == ST_POLL_POST) && faulted;
  assign raise_done = (state == ST_LAST);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nstate;
  end
endmodule

// File: rtl/ata_sector_reader.sv
module ata_sector_reader
  import ata_rd_pkg::*;
#(
  parameter int                 ADDR_W       = 10,
  parameter int                 DATA_W       = 32,
  parameter int                 SECTOR_BYTES = 512,
  parameter logic [ADDR_W-1:0]  BASE_PORT    = 10'h1F0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [LBA_BITS-1:0] req_lba,
  output logic                bus_stb,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [7:0]          bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                word_valid,
  output logic [DATA_W-1:0]   word_data,
  output logic                done,
  output logic                err
);
  localparam int WORDS = SECTOR_BYTES / (DATA_W / 8);

  seq_state_t          state;
  seq_state_t          nstate;
  logic                take_req;
  logic                word_cap;
  logic                raise_err;
  logic                raise_done;
  logic                last;
  logic [LBA_BITS-1:0] lba_q;
  port_op_t            op_next;

  ata_rd_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .status     (bus_rdata[7:0]),
    .last       (last),
    .state      (state),
    .nstate     (nstate),
    .take_req   (take_req),
    .word_cap   (word_cap),
    .raise_err  (raise_err),
    .raise_done (raise_done)
  );

  ata_rd_wordcnt #(.WORDS(WORDS)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (state == ST_IDLE),
    .inc  (word_cap),
    .last (last)
  );

  ata_rd_opgen u_opgen (
    .st  (nstate),
    .lba (lba_q),
    .op  (op_next)
  );

  always_ff @(posedge clk) begin
    if (rst)           lba_q <= '0;
    else if (take_req) lba_q <= req_lba;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_stb    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      bus_stb    <= op_next.stb;
      bus_we     <= op_next.we;
      bus_addr   <= BASE_PORT + {{(ADDR_W-OFS_W){1'b0}}, op_next.ofs};
      bus_wdata  <= op_next.wdata;
      word_valid <= word_cap;
      if (word_cap) word_data <= bus_rdata;
      done       <= raise_done;
      err        <= raise_err;
    end
  end
endmodule

// File: rtl/ata_sector_reader_chk.sv
module ata_sector_reader_chk #(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_PORT = 10'h1F0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_stb,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              word_valid,
  input logic              done,
  input logic              err
);
  localparam logic [ADDR_W-1:0] A_DATA = BASE_PORT;
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(BASE_PORT + 2);
  localparam logic [ADDR_W-1:0] A_DEV  = ADDR_W'(BASE_PORT + 6);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_PORT + 7);

  logic rd_stat, rd_data, wr_cnt, wr_dev, wr_cmd;
  assign rd_stat = bus_stb && !bus_we && (bus_addr == A_STAT);
  assign rd_data = bus_stb && !bus_we && (bus_addr == A_DATA);
  assign wr_cnt  = bus_stb && bus_we && (bus_addr == A_CNT);
  assign wr_dev  = bus_stb && bus_we && (bus_addr == A_DEV);
  assign wr_cmd  = bus_stb && bus_we && (bus_addr == A_STAT);

  p_poll_before_cnt_r1: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |-> $past(rd_stat));

  p_count_one_r2: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |-> (bus_wdata == 8'd1));

  p_dev_mode_r4: assert property (@(posedge clk) disable iff (rst)
    wr_dev |-> (bus_wdata[7:4] == 4'hE));

  p_cmd_after_dev_r5: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |-> ($past(wr_dev) && (bus_wdata == 8'h20)));

  p_data_after_poll_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !$past(rd_data)) |-> $past(rd_stat));

  p_word_from_read_r7: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(rd_data));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(word_valid) && !word_valid));

  p_err_after_poll_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(rd_stat) && !rd_data && !word_valid));
endmodule

bind ata_sector_reader ata_sector_reader_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_PORT (BASE_PORT)
) u_chk (.*);

// File: tb/ata_sector_reader_bench.sv
module ata_sector_reader_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [27:0] req_lba;
  logic        bus_stb, bus_we;
  logic [9:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [31:0] bus_rdata;
  logic        word_valid;
  logic [31:0] word_data;
  logic        done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_sector_reader u_ata_sector_reader (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_lba(req_lba),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .word_valid(word_valid), .word_data(word_data),
    .done(done), .err(err)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [27:0] l, input int k);
    return {l[11:0], 20'h0} ^ {4'h0, l} ^ (32'(k) * 32'h01000193);
  endfunction

  // drive model state
  logic [27:0] cur_lba;
  int  pre_busy, pre_nrdy, post_busy;
  bit  fault;
  int  phase;
  logic [9:0] wr_addr [8];
  logic [7:0] wr_data [8];
  int  nwr, nrd, nwords, done_seen, err_seen;
  bit  exp_done, exp_err, finished, quiet;

  initial begin
    phase = 0; nwr = 0; nrd = 0; nwords = 0; done_seen = 0; err_seen = 0;
    exp_done = 0; exp_err = 0; finished = 0; quiet = 0; bus_rdata = '0;
    pre_busy = 0; pre_nrdy = 0; post_busy = 0; fault = 0; cur_lba = '0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (exp_done) chk(done == 1'b1, "R8 done after last word", 32'(done), 1);
      else if (done) chk(1'b0, "R8 unexpected done", 1, 0);
      if (done) begin done_seen++; finished = 1; end
      exp_done = 0;
      if (exp_err) chk(err == 1'b1, "R9 err after fault status", 32'(err), 1);
      else if (err) chk(1'b0, "R9 unexpected err", 1, 0);
      if (err) begin err_seen++; finished = 1; end
      exp_err = 0;
      if (word_valid) begin
        chk(word_data == pat(cur_lba, nwords), "R7 word value", word_data,
            pat(cur_lba, nwords));
        nwords++;
        if (nwords == 128) exp_done = 1;
      end
      if (bus_stb) begin
        if (quiet) chk(1'b0, "R8 access while idle", 32'(bus_addr), 0);
        if (bus_we) begin
          if (phase == 0) chk(1'b0, "R1 write before ready", 32'(bus_addr), 0);
          if (nwr < 8) begin wr_addr[nwr] = bus_addr; wr_data[nwr] = bus_wdata; end
          nwr++;
          if (bus_addr == 10'h1F7) phase = 2;
        end else if (bus_addr == 10'h1F7) begin
          if (phase < 2) begin
            if (pre_busy > 0) begin bus_rdata = 32'h80; pre_busy--; end
            else if (pre_nrdy > 0) begin bus_rdata = 32'h10; pre_nrdy--; end
            else begin bus_rdata = 32'h50; phase = 1; end
          end else begin
            if (post_busy > 0) begin bus_rdata = 32'hC1; post_busy--; end
            else if (fault) begin bus_rdata = 32'h51; exp_err = 1; end
            else begin bus_rdata = 32'h58; phase = 3; end
          end
        end else if (bus_addr == 10'h1F0) begin
          if (phase != 3) chk(1'b0, "R6 data read before ready", 32'(phase), 3);
          bus_rdata = pat(cur_lba, nrd);
          nrd++;
        end else begin
          chk(1'b0, "R5 read of unexpected port", 32'(bus_addr), 0);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run(input logic [27:0] lba, input int b1, input int n1,
                     input int b2, input bit e, input bit ign);
    int waited;
    step();
    cur_lba = lba; pre_busy = b1; pre_nrdy = n1; post_busy = b2; fault = e;
    phase = 0; nwr = 0; nrd = 0; nwords = 0; done_seen = 0; err_seen = 0;
    finished = 0;
    req_valid = 1'b1; req_lba = lba;
    step();
    req_valid = 1'b0; req_lba = ~lba;
    if (ign) begin
      repeat (3) step();
      req_valid = 1'b1;
      repeat (15) step();
      req_valid = 1'b0;
    end
    waited = 0;
    while (!finished && waited < 3000) begin step(); waited++; end
    chk(finished, "R8 transfer finished", 32'(finished), 1);
    quiet = 1;
    repeat (6) step();
    quiet = 0;
    chk(nwr == 6, "R5 write count", 32'(nwr), 6);
    if (nwr >= 6) begin
      for (int i = 0; i < 6; i++)
        chk(wr_addr[i] == 10'(10'h1F2 + i), "R5 write order", 32'(wr_addr[i]),
            32'(10'h1F2 + i));
      chk(wr_data[0] == 8'd1, "R2 sector count", 32'(wr_data[0]), 1);
      chk(wr_data[1] == lba[7:0], "R3 address byte 0", 32'(wr_data[1]), 32'(lba[7:0]));
      chk(wr_data[2] == lba[15:8], "R3 address byte 1", 32'(wr_data[2]), 32'(lba[15:8]));
      chk(wr_data[3] == lba[23:16], "R3 address byte 2", 32'(wr_data[3]), 32'(lba[23:16]));
      chk(wr_data[4] == (8'hE0 | {4'h0, lba[27:24]}), "R4 device byte",
          32'(wr_data[4]), 32'(8'hE0 | {4'h0, lba[27:24]}));
      chk(wr_data[5] == 8'h20, "R5 command", 32'(wr_data[5]), 32'h20);
    end
    if (ign) chk(nwr == 6 && nrd == 128, "R10 request ignored mid-transfer",
                 32'(nwr), 6);
    if (e) begin
      chk(nrd == 0, "R9 no data reads", 32'(nrd), 0);
      chk(nwords == 0, "R9 no words", 32'(nwords), 0);
      chk(err_seen == 1, "R9 one err pulse", 32'(err_seen), 1);
      chk(done_seen == 0, "R9 no done", 32'(done_seen), 0);
    end else begin
      chk(nrd == 128, "R7 data reads", 32'(nrd), 128);
      chk(nwords == 128, "R7 words out", 32'(nwords), 128);
      chk(done_seen == 1, "R8 one done pulse", 32'(done_seen), 1);
      chk(err_seen == 0, "R6 no err", 32'(err_seen), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_lba = '0;
    repeat (4) step();
    chk({bus_stb, word_valid, done, err} == 4'b0, "R11 outputs in reset",
        32'({bus_stb, word_valid, done, err}), 0);
    rst = 1'b0;
    repeat (3) step();
    chk({bus_stb, word_valid, done, err} == 4'b0, "R11 outputs after reset",
        32'({bus_stb, word_valid, done, err}), 0);

    run(28'h0000000, 0, 0, 0, 1'b0, 1'b0);
    run(28'hFFFFFFF, 0, 0, 0, 1'b0, 1'b0);
    for (int b1 = 0; b1 < 3; b1++)
      for (int n1 = 0; n1 < 2; n1++)
        for (int b2 = 0; b2 < 3; b2++)
          for (int e = 0; e < 2; e++)
            run(28'((b1 * 12 + n1 * 6 + b2 * 2 + e + 1) * 28'h1D3A5B7),
                b1, n1, b2, e[0], 1'b0);
    run(28'hA5C3E17, 1, 0, 1, 1'b0, 1'b1);
    run(28'h3000001, 0, 1, 2, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule